// File: doc/BRIEF.md
# Masked-Write Pin Function Select Bank

This block holds the alternate-function selection for one bank of 32 pins. Software writes it over a small register bus. Each 32-bit write carries its own bit-enable mask in the upper halfword, so a single field can be changed without first reading the register back. Other logic reads the selected function of any pin through a combinational lookup port. That port takes a pin index and returns the function code, or an error flag when the pin cannot be resolved.

The pins form four groups of eight. At elaboration time each group is given a field width of 2, 3 or 4 bits. A group can also be marked GPIO-only, which means it has no storage and always selects function 0. Alternatively it can be marked unrouted, which means its lookups fail. The registers of the groups are placed back to back from a base offset. A group with a preset start offset moves the running offset to that address. A 2-bit group takes one word and a 3-bit or 4-bit group takes two. All addresses are byte addresses, and only word-aligned ones are decoded.

Top module: `pin_func_bank`

## Requirements
- R1: On a write to a stored register, each bit k of the lower halfword (k = 0..15) takes write-data bit k only when write-data bit 16+k is 1; every other bit keeps its value.
- R2: When the write strobe is low, or the enable halfword is all zero, no stored bit changes.
- R3: After reset every stored field is 0, so every routed pin looks up as function 0 with no error.
- R4: A read returns 0 in bits 31:16 and the 16 stored bits in bits 15:0.
- R5: In a 2-bit group, local pin p (0..7) uses bits 2p+1:2p of the group's single register.
- R6: In a 3-bit group, local pins 0..4 use bits 3p+2:3p of the first register, and pins 5..7 use bits 3(p-5)+2:3(p-5) of the register 4 bytes higher.
- R7: In a 4-bit group, local pins 0..3 use bits 4p+3:4p of the first register, and pins 4..7 use bits 4(p-4)+3:4(p-4) of the register 4 bytes higher.
- R8: Group start addresses run back to back from the base offset. A 2-bit group advances the offset by 4 and a 3-bit or 4-bit group by 8, and a preset start replaces the running offset. In the default build, group 0 (2-bit) is at 0x00, group 1 (3-bit) at 0x04/0x08, group 2 (4-bit, preset 0x20) at 0x20/0x24, and group 3 (2-bit, GPIO-only) at 0x28.
- R9: For a GPIO-only group, lookups return function 0 with no error, its registers read 0, and writes to them have no effect.
- R10: For an unrouted group, lookups return the error flag with function 0, and its registers read 0.
- R11: A lookup pin index of 32 or more returns the error flag with function 0.
- R12: A read of an unmapped or non-word-aligned address returns 0, and a write to such an address changes nothing.
- R13: The lookup output is combinational. It shows the old field value until the clock edge that takes a write, and the new value from that edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data: bit enables in 31:16, values in 15:0 |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| lk_pin | input | 6 | Pin index for the lookup |
| lk_func | output | 4 | Selected function code, zero-extended |
| lk_err | output | 1 | Lookup failed: unrouted group or index out of range |

## Verification
A decode error that points a pin at the wrong register or bit offset shows up at once on lk_func. The wrong pin's field appears there as soon as a neighbouring field is written. For this reason the bench compares all 32 lookups against its own model after every write. A mask that is handled wrongly corrupts bits outside the enabled set, and the readback in the cycle after the write exposes it. A layout offset that is off by a word either aliases two groups or drops a register. That is caught by reading unmapped, aligned, misaligned and GPIO-only addresses after writes of all ones.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

   localparam int NUM_GRP    = 4;
   localparam int GRP_PINS   = 8;
   localparam int HALF_W     = 16;
   localparam int FUNC_W     = 4;
   localparam int PIN_IDX_W  = 6;

   // Location of one pin's field inside its group: which of the two
   // group words holds it, and the bit at which it starts.
   typedef struct packed {
      logic       upper_word;
      logic [3:0] lsb;
   } fld_loc_t;

   // Bytes of address space a group with the given field width takes.
   function automatic int grp_span(input int width);
      return (width == 2) ? 4 : 8;
   endfunction

   // Number of stored words a group with the given width needs.
   function automatic int grp_words(input int width);
      return (width == 2) ? 1 : 2;
   endfunction

   // Packing of local pin p (0..7) for each field width.
   function automatic fld_loc_t locate(input int width, input logic [2:0] lp);
      fld_loc_t r;
      int       p;
      p = int'(lp);
      case (width)
         3: begin
            r.upper_word = (p >= 5);
            r.lsb        = (p >= 5) ? 4'((p - 5) * 3) : 4'(p * 3);
         end
         4: begin
            r.upper_word = (p >= 4);
            r.lsb        = (p >= 4) ? 4'((p - 4) * 4) : 4'(p * 4);
         end
         default: begin
            r.upper_word = 1'b0;
            r.lsb        = 4'(p * 2);
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pmx_mask_reg.sv
module pmx_mask_reg
   import pmx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [31:0]       wdata,
   output logic [HALF_W-1:0] q
);

   logic [HALF_W-1:0] bit_en;
   logic [HALF_W-1:0] new_val;

   assign bit_en  = wdata[31:16];
   assign new_val = wdata[15:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= (q & ~bit_en) | (new_val & bit_en);
   end

   // R1: enabled bits take the new value
   a_r1_enabled_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & $past(bit_en)) == ($past(new_val) & $past(bit_en))));

   // R1: bits without an enable keep their old value
   a_r1_other_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((q & ~$past(bit_en)) == ($past(q) & ~$past(bit_en))));

   // R2: no strobe, no change
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/pmx_group.sv
module pmx_group
   import pmx_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              MUXW      = 2,
   parameter bit              GPIO_ONLY = 1'b0,
   parameter bit              UNROUTED  = 1'b0,
   parameter logic [ADDR_W-1:0] START   = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [31:0]       wdata,
   input  logic [2:0]        lp,
   output logic [HALF_W-1:0] rd_data,
   output logic [FUNC_W-1:0] func,
   output logic              err
);

   localparam int                NWORDS    = grp_words(MUXW);
   localparam bit                HAS_STORE = !GPIO_ONLY && !UNROUTED;
   localparam logic [ADDR_W-1:0] START_HI  = ADDR_W'(START + ADDR_W'(4));

   logic [1:0]              hit;
   logic [1:0][HALF_W-1:0]  words;
   fld_loc_t                loc;
   logic [HALF_W-1:0]       sel_word;
   logic [FUNC_W-1:0]       raw_func;

   assign hit[0] = (addr == START);

   generate
      if (NWORDS == 2) begin : g_two_words
         assign hit[1] = (addr == START_HI);
      end else begin : g_one_word
         assign hit[1] = 1'b0;
      end
   endgenerate

   // Storage, generated only for groups that own their fields.
   genvar w;
   generate
      for (w = 0; w < 2; w++) begin : g_word
         if (HAS_STORE && (w < NWORDS)) begin : g_store
            pmx_mask_reg i_word (
               .clk   (clk),
               .rst_n (rst_n),
               .we    (we && hit[w]),
               .wdata (wdata),
               .q     (words[w])
            );
         end else begin : g_none
            assign words[w] = '0;
         end
      end
   endgenerate

   // Register read
   always_comb begin
      rd_data = '0;
      if (hit[0])
         rd_data = words[0];
      else if (hit[1])
         rd_data = words[1];
   end

   // Pin lookup
   assign loc      = locate(MUXW, lp);
   assign sel_word = loc.upper_word ? words[1] : words[0];

   genvar b;
   generate
      for (b = 0; b < FUNC_W; b++) begin : g_fbit
         if (b < MUXW) begin : g_live
            assign raw_func[b] = sel_word[loc.lsb + 4'(b)];
         end else begin : g_pad
            assign raw_func[b] = 1'b0;
         end
      end
   endgenerate

   generate
      if (UNROUTED) begin : g_unrouted
         assign func = '0;
         assign err  = 1'b1;
      end else if (GPIO_ONLY) begin : g_gpio
         assign func = '0;
         assign err  = 1'b0;
      end else begin : g_routed
         assign func = raw_func;
         assign err  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pin_func_bank.sv
module pin_func_bank
   import pmx_pkg::*;
#(
   parameter int                          ADDR_W        = 8,
   parameter int                          BASE_OFFS     = 0,
   parameter logic [3:0][2:0]             GRP_W         = {3'd2, 3'd4, 3'd3, 3'd2},
   parameter logic [3:0]                  GRP_GPIO_ONLY = 4'b1000,
   parameter logic [3:0]                  GRP_UNROUTED  = 4'b0000,
   parameter logic [3:0]                  GRP_PRESET_EN = 4'b0100,
   parameter logic [3:0][ADDR_W-1:0]      GRP_PRESET    = {8'h00, 8'h20, 8'h00, 8'h00}
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   input  logic [5:0]        lk_pin,
   output logic [3:0]        lk_func,
   output logic              lk_err
);

   localparam int ADDR_SPACE = 1 << ADDR_W;

   // Start address of group g, following presets and running offsets.
   function automatic int grp_start(input int g);
      int cur;
      int s;
      cur = BASE_OFFS;
      s   = BASE_OFFS;
      for (int i = 0; i <= g; i++) begin
         s   = GRP_PRESET_EN[i] ? int'(GRP_PRESET[i]) : cur;
         cur = s + grp_span(int'(GRP_W[i]));
      end
      return s;
   endfunction

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr_w
         $error("pin_func_bank: ADDR_W must be 3..16");
      end
      if ((BASE_OFFS % 4) != 0) begin : g_bad_base
         $error("pin_func_bank: BASE_OFFS must be word aligned");
      end
   endgenerate

   genvar gc, gd;
   generate
      for (gc = 0; gc < NUM_GRP; gc++) begin : g_check
         if (GRP_W[gc] < 3'd2 || GRP_W[gc] > 3'd4) begin : g_bad_width
            $error("pin_func_bank: group width must be 2, 3 or 4");
         end
         if (GRP_GPIO_ONLY[gc] && GRP_UNROUTED[gc]) begin : g_bad_flags
            $error("pin_func_bank: a group cannot be GPIO-only and unrouted");
         end
         if ((grp_start(gc) % 4) != 0) begin : g_bad_align
            $error("pin_func_bank: group start must be word aligned");
         end
         if (grp_start(gc) + grp_span(int'(GRP_W[gc])) > ADDR_SPACE) begin : g_bad_range
            $error("pin_func_bank: group does not fit the address space");
         end
         for (gd = gc + 1; gd < NUM_GRP; gd++) begin : g_pair
            if ((grp_start(gc) < grp_start(gd) + grp_span(int'(GRP_W[gd]))) &&
                (grp_start(gd) < grp_start(gc) + grp_span(int'(GRP_W[gc])))) begin : g_overlap
               $error("pin_func_bank: group address ranges overlap");
            end
         end
      end
   endgenerate

   logic [NUM_GRP-1:0][HALF_W-1:0] grp_rd;
   logic [NUM_GRP-1:0][FUNC_W-1:0] grp_func;
   logic [NUM_GRP-1:0]             grp_err;

   genvar g;
   generate
      for (g = 0; g < NUM_GRP; g++) begin : g_grp
         pmx_group #(
            .ADDR_W    (ADDR_W),
            .MUXW      (int'(GRP_W[g])),
            .GPIO_ONLY (GRP_GPIO_ONLY[g]),
            .UNROUTED  (GRP_UNROUTED[g]),
            .START     (ADDR_W'(grp_start(g)))
         ) i_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (bus_addr),
            .we      (bus_we),
            .wdata   (bus_wdata),
            .lp      (lk_pin[2:0]),
            .rd_data (grp_rd[g]),
            .func    (grp_func[g]),
            .err     (grp_err[g])
         );
      end
   endgenerate

   // Groups occupy disjoint ranges, so at most one drives a nonzero word.
   always_comb begin
      logic [HALF_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < NUM_GRP; i++)
         acc = acc | grp_rd[i];
      bus_rdata = {16'h0000, acc};
   end

   always_comb begin
      if (lk_pin[5]) begin
         lk_func = '0;
         lk_err  = 1'b1;
      end else begin
         lk_func = grp_func[lk_pin[4:3]];
         lk_err  = grp_err[lk_pin[4:3]];
      end
   end

   // R9: GPIO-only pins resolve to function 0 without error
   a_r9_gpio_lookup_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_pin[5] && GRP_GPIO_ONLY[lk_pin[4:3]]) |-> (lk_func == '0 && !lk_err));

   // R10 / R11: a failed lookup never carries a function code
   a_r11_err_func_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lk_err |-> (lk_func == '0));

   // R11: indices of 32 and above are rejected
   a_r11_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
      lk_pin[5] |-> lk_err);

   // R4: upper read halfword is always clear
   a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:16] == 16'h0000);

endmodule

// File: tb/test_pin_func_bank.sv
module test_pin_func_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata, u_rdata;
   logic [5:0]  lk_pin = '0;
   logic [3:0]  lk_func, u_func;
   logic        lk_err, u_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pin_func_bank i_pin_func_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .lk_pin(lk_pin),
      .lk_func(lk_func), .lk_err(lk_err)
   );

   // Second build: group 1 unrouted
   pin_func_bank #(.GRP_UNROUTED(4'b0010)) i_pin_func_bank_u (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(u_rdata), .lk_pin(lk_pin),
      .lk_func(u_func), .lk_err(u_err)
   );

   // Bench model of the default layout (R8)
   logic [15:0] shadow [16];
   localparam int MW [4]   = '{2, 3, 4, 2};
   localparam int MB [4]   = '{8'h00, 8'h04, 8'h20, 8'h28};

   function automatic bit stored(input logic [7:0] a);
      return (a == 8'h00) || (a == 8'h04) || (a == 8'h08) ||
             (a == 8'h20) || (a == 8'h24);
   endfunction

   function automatic logic [3:0] exp_func(input int pin);
      int g, lp, w, word, lsb;
      logic [15:0] v;
      g = pin / 8; lp = pin % 8; w = MW[g]; word = MB[g]; lsb = 2 * lp;
      if (g == 3) return 4'h0;
      if (w == 3) begin
         if (lp >= 5) begin word = word + 4; lsb = 3 * (lp - 5); end
         else lsb = 3 * lp;
      end else if (w == 4) begin
         if (lp >= 4) begin word = word + 4; lsb = 4 * (lp - 4); end
         else lsb = 4 * lp;
      end
      v = shadow[word / 4] >> lsb;
      return 4'(v & 16'((1 << w) - 1));
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      if (stored(a))
         shadow[a / 4] = (shadow[a / 4] & ~d[31:16]) | (d[15:0] & d[31:16]);
   endtask

   task automatic read_check(input string req, input logic [7:0] a, input logic [15:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, {16'h0000, exp});
   endtask

   task automatic lookup_all(input string req);
      for (int p = 0; p < 32; p++) begin
         lk_pin = 6'(p);
         #1;
         check(req, {27'h0, lk_err, lk_func}, {27'h0, 1'b0, exp_func(p)});
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) shadow[i] = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   typedef struct packed {
      logic [7:0]  a;
      logic [31:0] wd;
      logic [15:0] exp;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{8'h00, 32'hFFFF_1B1B, 16'h1B1B},  // R1 R5 full write, 2-bit group
      '{8'h00, 32'h0300_0000, 16'h181B},  // R1 clear only bits 9:8
      '{8'h04, 32'hFFFF_6A5B, 16'h6A5B},  // R6 3-bit group, low word
      '{8'h08, 32'h01FF_0123, 16'h0123},  // R6 3-bit group, high word
      '{8'h20, 32'hFFFF_FEDC, 16'hFEDC},  // R7 R8 4-bit group at preset
      '{8'h24, 32'h00F0_5A3C, 16'h0030},  // R1 R7 partial mask, high word
      '{8'h28, 32'hFFFF_FFFF, 16'h0000},  // R9 GPIO-only register
      '{8'h0C, 32'hFFFF_FFFF, 16'h0000},  // R12 unmapped gap
      '{8'h02, 32'hFFFF_FFFF, 16'h0000},  // R12 misaligned
      '{8'h00, 32'h0000_FFFF, 16'h181B}   // R2 empty enable half
   };

   initial begin
      #(8 * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R3: reset state of registers and lookups
      for (int a = 0; a < 64; a += 4) read_check("R3", 8'(a), 16'h0000);
      lookup_all("R3");

      // R11: out-of-range pin indices
      lk_pin = 6'd32; #1; check("R11", {27'h0, lk_err, lk_func}, 32'h10);
      lk_pin = 6'd63; #1; check("R11", {27'h0, lk_err, lk_func}, 32'h10);

      // Vector walk: write, read back, then every lookup (R1 R2 R4-R9 R12)
      for (int i = 0; i < 10; i++) begin
         bus_write(VECS[i].a, VECS[i].wd);
         read_check("R1/R4 vector readback", VECS[i].a, VECS[i].exp);
         lookup_all("R5/R6/R7 lookup");
      end

      // R12: unaligned write did not alias into word 0x00
      read_check("R12", 8'h00, 16'h181B);
      read_check("R12", 8'h10, 16'h0000);
      // R9: GPIO-only pins still look up as function 0
      lk_pin = 6'd27; #1; check("R9", {27'h0, lk_err, lk_func}, 32'h0);

      // R2: strobe low leaves state alone
      @(negedge clk);
      bus_addr = 8'h20; bus_wdata = 32'hFFFF_0000; bus_we = 1'b0;
      @(negedge clk);
      read_check("R2", 8'h20, 16'hFEDC);

      // R13: lookup shows old value before the edge, new value after it
      lk_pin = 6'd0;
      bus_addr = 8'h00; bus_wdata = 32'h0003_0000; bus_we = 1'b1;
      #1;
      check("R13 before edge", {28'h0, lk_func}, 32'h3);
      @(negedge clk);
      bus_we = 1'b0;
      shadow[0] = 16'h1818;
      #1;
      check("R13 after edge", {28'h0, lk_func}, 32'h0);

      // R10: unrouted group in the second build
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_addr = 8'h04; #1;
      check("R10 readback", u_rdata, 32'h0);
      check("R10 main build", bus_rdata, 32'h0000_FFFF);
      lk_pin = 6'd9; #1;
      check("R10 lookup", {27'h0, u_err, u_func}, 32'h10);
      lk_pin = 6'd1; #1;
      check("R10 other group", {27'h0, u_err, u_func}, 32'h2);

      // R3: reset in mid-run clears stored fields
      do_reset();
      read_check("R3", 8'h20, 16'h0000);
      read_check("R3", 8'h04, 16'h0000);
      lookup_all("R3");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule